// File: doc/BRIEF.md
# Two-Level Shared Interrupt Aggregator

This block gathers the interrupt sources of a CompactFlash-style host controller and combines them with the request of a neighbouring storage controller onto one interrupt line. At the first level, single-cycle event pulses and card-presence changes set bits in a local status register. Software clears these bits by writing ones. A local enable register selects which of these bits take part in the controller's combined request.

At the second level, a rising edge of that combined request sets this controller's bit in a global status register. The sibling controller's request sets the other global bit. A global bit drives the interrupt line only when its status-enable bit and its signal-enable bit are both set.

Card presence comes from two active-low detect pins. Each pin passes through a two-flop synchronizer. The presence decision is then debounced: a new value must hold for a set number of cycles before it counts. Registers are reached through a simple 32-bit port addressed by word index: 0 interface status, 1 local status, 2 local enable, 3 global status, 4 global status-enable, 5 global signal-enable.

Top module: `cf_irq_aggregator`

## Requirements
- R1: While `rst_n` is low, every readable register returns 0 at the next clock edge and `irq_out` is 0.
- R2: Writing to local status (index 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A pulse on `ev_in` sets the local status bit of the same position for positions 1, 2, 3, 8, 9, 10 and 11 (status change, memory mode, I/O mode, IDE mode, PIO error, buffer available, transfer done). `ev_in` bits 0 and 4–7 have no effect, and those positions read 0 unless noted in R8.
- R4: If an event and a write-one-to-clear hit the same local status bit in the same cycle, the bit stays set.
- R5: Local enable (index 2) stores only bits 0–3 and 8–11. Any other bit reads 0.
- R6: Bit 0 of global status (index 3) is set when the OR of local status AND local enable goes from 0 to 1. If software clears bit 0 while that OR stays high, the bit is not set again. A high `sib_irq` sets bit 1. Writing 1 to a global bit clears it.
- R7: One cycle after some global bit has its status bit, its status-enable bit (index 4) and its signal-enable bit (index 5) all set, `irq_out` is 1; otherwise it is 0. The two global enable registers store only bits 0–1.
- R8: The card is present only when both synchronized detect pins are low. A presence change that holds for `DEB_CYCLES` cycles sets local status bit 0, both on insertion and on removal.
- R9: A change in presence that lasts fewer than `DEB_CYCLES` cycles does not set local status bit 0.
- R10: Interface status (index 0) reads the synchronized detect pin 1 at bit 2, detect pin 2 at bit 3, `card_rdy` at bit 5 and `io_rdy` at bit 6. Word indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_in | input | 12 | Event pulses, one bit per local status position |
| cd1_n | input | 1 | Card detect pin 1, active low, asynchronous |
| cd2_n | input | 1 | Card detect pin 2, active low, asynchronous |
| card_rdy | input | 1 | Card ready level, shown in interface status |
| io_rdy | input | 1 | I/O ready level, shown in interface status |
| sib_irq | input | 1 | Request from the sibling controller |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A wrong local status or enable bit appears on the read port in the cycle right after the edge that caused it. It also appears at `irq_out` two edges later: one edge for the global set and one for the output register. A lost or extra edge in the summary detector shows up as a global bit 0 that is missing, or that comes back after it was cleared. A fault in the presence filter shows up as a card-detect bit set too early, set by a short glitch, or never set. The filter's window is `DEB_CYCLES` plus the two synchronizer stages, so such a fault appears within about ten cycles of a pin change.

// File: rtl/cf_irq_pkg.sv
// Shared constants for the interrupt aggregator: local bit positions,
// implemented-bit masks and the register index map.
package cf_irq_pkg;
    localparam int LOC_W  = 12;
    localparam int GLB_W  = 2;
    localparam int BIT_CD = 0;
    localparam int BIT_PIOERR = 9;
    localparam int BIT_BUFAV  = 10;
    // bits that exist in local status / enable
    localparam logic [LOC_W-1:0] LOC_IMPL = 12'hF0F;
    // bits that an event pulse may set (card detect comes from the pins)
    localparam logic [LOC_W-1:0] EVT_IMPL = 12'hF0E;

    typedef enum logic [2:0] {
        RA_IFSTAT = 3'd0,
        RA_LSTAT  = 3'd1,
        RA_LEN    = 3'd2,
        RA_GSTAT  = 3'd3,
        RA_GSEN   = 3'd4,
        RA_GSGN   = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/cf_cd_filter.sv
// Card presence filter.
// Synchronizes the two active-low detect pins, computes presence
// (both low) and accepts a new presence value only after it has held
// for DEB_CYCLES consecutive cycles. Emits a one-cycle change pulse.
// Assumes SYNC_STAGES >= 2 and DEB_CYCLES >= 1.
module cf_cd_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cd_n,
    output logic [1:0] cd_sync,
    output logic       present,
    output logic       change
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [1:0][SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]            cnt_q;
    logic                        raw_present;

    // shift each pin through its synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                sync_q[p] <= {sync_q[p][SYNC_STAGES-2:0], cd_n[p]};
            end
        end
    end

    always_comb begin
        cd_sync[0] = sync_q[0][SYNC_STAGES-1];
        cd_sync[1] = sync_q[1][SYNC_STAGES-1];
    end

    assign raw_present = ~cd_sync[0] & ~cd_sync[1];
    assign change      = (raw_present != present) && (cnt_q == CNT_LAST);

    // count cycles of disagreement; accept the new value at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            present <= 1'b0;
        end else if (raw_present == present) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            present <= raw_present;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cf_irq_local.sv
// Local status/enable pair.
// Status bits are set by set_vec and cleared by writing ones. A set wins
// over a clear in the same cycle. Only IMPL bits exist. Summary is the OR
// of status AND enable.
module cf_irq_local #(
    parameter int               W    = 12,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         summary
);
    logic [W-1:0] clr_mask;

    assign clr_mask = clr_we ? wdata : '0;

    // write-one-to-clear status, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= ((stat & ~clr_mask) | set_vec) & IMPL;
    end

    // plain read/write enable
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= wdata & IMPL;
    end

    assign summary = |(stat & en);
endmodule

// File: rtl/cf_irq_global.sv
// Global status level.
// Each bit is set by its requester and cleared by writing one. A bit
// drives the registered output only when its status-enable and
// signal-enable bits are both set.
module cf_irq_global #(
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] set_vec,
    input  logic          clr_we,
    input  logic          sen_we,
    input  logic          sgn_we,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] gstat,
    output logic [GW-1:0] gsen,
    output logic [GW-1:0] gsgn,
    output logic          irq_out
);
    // write-one-to-clear global status, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)      gstat <= '0;
        else if (clr_we) gstat <= (gstat & ~wdata) | set_vec;
        else             gstat <= gstat | set_vec;
    end

    // both enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsen <= '0;
            gsgn <= '0;
        end else begin
            if (sen_we) gsen <= wdata;
            if (sgn_we) gsgn <= wdata;
        end
    end

    // registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(gstat & gsen & gsgn);
    end
endmodule

// File: rtl/cf_irq_aggregator.sv
// Top of the two-level interrupt aggregator.
// Decodes the register port, routes events and the presence change into
// the local level, detects the rising edge of the local summary and
// feeds it with the sibling request into the global level.
// Assumes single-cycle writes and a combinational read.
module cf_irq_aggregator
    import cf_irq_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LOC_W-1:0]  ev_in,
    input  logic              cd1_n,
    input  logic              cd2_n,
    input  logic              card_rdy,
    input  logic              io_rdy,
    input  logic              sib_irq,
    output logic              irq_out
);
    logic [1:0]       cd_sync;
    logic             cd_present;
    logic             cd_change;
    logic [LOC_W-1:0] lstat_w, len_w, loc_set;
    logic             loc_sum, loc_sum_q;
    logic [GLB_W-1:0] gstat_w, gsen_w, gsgn_w, glb_set;
    logic             we_lstat, we_len, we_gstat, we_gsen, we_gsgn;

    // decode write strobes
    always_comb begin
        we_lstat = reg_we && (reg_addr == ADDR_W'(RA_LSTAT));
        we_len   = reg_we && (reg_addr == ADDR_W'(RA_LEN));
        we_gstat = reg_we && (reg_addr == ADDR_W'(RA_GSTAT));
        we_gsen  = reg_we && (reg_addr == ADDR_W'(RA_GSEN));
        we_gsgn  = reg_we && (reg_addr == ADDR_W'(RA_GSGN));
    end

    cf_cd_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_CYCLES (DEB_CYCLES)
    ) u_cd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cd_n   ({cd2_n, cd1_n}),
        .cd_sync(cd_sync),
        .present(cd_present),
        .change (cd_change)
    );

    // event pulses plus presence change
    always_comb begin
        loc_set         = ev_in & EVT_IMPL;
        loc_set[BIT_CD] = cd_change;
    end

    cf_irq_local #(
        .W   (LOC_W),
        .IMPL(LOC_IMPL)
    ) u_loc (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(loc_set),
        .clr_we (we_lstat),
        .en_we  (we_len),
        .wdata  (reg_wdata[LOC_W-1:0]),
        .stat   (lstat_w),
        .en     (len_w),
        .summary(loc_sum)
    );

    // remember the summary for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) loc_sum_q <= 1'b0;
        else        loc_sum_q <= loc_sum;
    end

    assign glb_set = {sib_irq, loc_sum & ~loc_sum_q};

    cf_irq_global #(
        .GW(GLB_W)
    ) u_glb (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(glb_set),
        .clr_we (we_gstat),
        .sen_we (we_gsen),
        .sgn_we (we_gsgn),
        .wdata  (reg_wdata[GLB_W-1:0]),
        .gstat  (gstat_w),
        .gsen   (gsen_w),
        .gsgn   (gsgn_w),
        .irq_out(irq_out)
    );

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(RA_IFSTAT): begin
                reg_rdata[2] = cd_sync[0];
                reg_rdata[3] = cd_sync[1];
                reg_rdata[5] = card_rdy;
                reg_rdata[6] = io_rdy;
            end
            ADDR_W'(RA_LSTAT): reg_rdata[LOC_W-1:0] = lstat_w;
            ADDR_W'(RA_LEN):   reg_rdata[LOC_W-1:0] = len_w;
            ADDR_W'(RA_GSTAT): reg_rdata[GLB_W-1:0] = gstat_w;
            ADDR_W'(RA_GSEN):  reg_rdata[GLB_W-1:0] = gsen_w;
            ADDR_W'(RA_GSGN):  reg_rdata[GLB_W-1:0] = gsgn_w;
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cf_irq_aggregator_chk.sv
// Property checker for the aggregator, attached by bind.
// Watches register state and the interrupt line over time.
module cf_irq_aggregator_chk
    import cf_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LOC_W-1:0] ev_in,
    input logic             irq_out,
    input logic [LOC_W-1:0] lstat,
    input logic [LOC_W-1:0] len,
    input logic [GLB_W-1:0] gstat,
    input logic [GLB_W-1:0] gsen,
    input logic [GLB_W-1:0] gsgn
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && lstat == '0 && gstat == '0)); // R1

    AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lstat[BIT_PIOERR]) |-> $past(ev_in[BIT_PIOERR])); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in[BIT_BUFAV] |=> lstat[BIT_BUFAV]); // R4

    AST_GSELF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstat[0]) |-> $past(|(lstat & len))); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(gstat & gsen & gsgn))); // R7
endmodule

bind cf_irq_aggregator cf_irq_aggregator_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_in  (ev_in),
    .irq_out(irq_out),
    .lstat  (lstat_w),
    .len    (len_w),
    .gstat  (gstat_w),
    .gsen   (gsen_w),
    .gsgn   (gsgn_w)
);

// File: tb/sim_cf_irq_aggregator.sv
// Bench: register vector table, then directed reset, global and detect tests.
module sim_cf_irq_aggregator;
    localparam int DEB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] ev_in = '0;
    logic        cd1_n = 1'b1;
    logic        cd2_n = 1'b1;
    logic        card_rdy = 1'b0;
    logic        io_rdy = 1'b0;
    logic        sib_irq = 1'b0;
    logic        irq_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cf_irq_aggregator #(.DEB_CYCLES(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in),
        .cd1_n(cd1_n), .cd2_n(cd2_n), .card_rdy(card_rdy), .io_rdy(io_rdy),
        .sib_irq(sib_irq), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [11:0] ev;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd2, 32'hFFFF_FFFF, 12'h000, 32'h0000_0F0F, 4'd5},  // R5
        '{1'b0, 3'd1, 32'h0,         12'hE13, 32'h0000_0E02, 4'd3},  // R3
        '{1'b1, 3'd1, 32'h0000_0200, 12'h000, 32'h0000_0C02, 4'd2},  // R2
        '{1'b1, 3'd1, 32'h0,         12'h000, 32'h0000_0C02, 4'd2},  // R2
        '{1'b1, 3'd1, 32'h0000_0400, 12'h400, 32'h0000_0C02, 4'd4},  // R4
        '{1'b1, 3'd1, 32'hFFFF_FFFF, 12'h000, 32'h0,         4'd2},  // R2
        '{1'b0, 3'd1, 32'h0,         12'h10C, 32'h0000_010C, 4'd3},  // R3
        '{1'b1, 3'd1, 32'hFFFF_FFFF, 12'h000, 32'h0,         4'd2},  // R2
        '{1'b0, 3'd7, 32'h0,         12'h000, 32'h0,         4'd10}, // R10
        '{1'b1, 3'd4, 32'hFFFF_FFFF, 12'h000, 32'h0000_0003, 4'd7},  // R7
        '{1'b1, 3'd4, 32'h0,         12'h000, 32'h0,         4'd7}   // R7
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp,
                            input string req);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cycles(3);
        for (int a = 0; a < 6; a++) rd_check(3'(a), 32'h0, "R1");
        check({31'b0, irq_out}, 32'h0, "R1");
        rst_n = 1'b1;
        cycles(3);
        rd_check(3'd0, 32'h0000_000C, "R10");

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_addr = VEC[i].addr; reg_wdata = VEC[i].data;
            reg_we = VEC[i].we;     ev_in = VEC[i].ev;
            @(negedge clk);
            reg_we = 1'b0; ev_in = '0;
            #1;
            checks++;
            if (reg_rdata !== VEC[i].exp) begin
                errors++;
                $display("FAIL R%0d vec %0d: actual %h expected %h",
                         VEC[i].req, i, reg_rdata, VEC[i].exp);
            end
        end

        // R6: summary edges recorded, then cleared
        rd_check(3'd3, 32'h1, "R6");
        wr(3'd3, 32'h3);
        rd_check(3'd3, 32'h0, "R6");
        @(negedge clk); ev_in = 12'h200;
        @(negedge clk); ev_in = '0;
        @(negedge clk);
        rd_check(3'd3, 32'h1, "R6");
        wr(3'd3, 32'h1);
        cycles(3);
        rd_check(3'd3, 32'h0, "R6 no re-set while summary high");
        wr(3'd1, 32'hFFF);

        // R7: sibling request through both gates
        @(negedge clk); sib_irq = 1'b1;
        @(negedge clk); sib_irq = 1'b0;
        rd_check(3'd3, 32'h2, "R6 sibling");
        wr(3'd4, 32'h2);
        cycles(2);
        check({31'b0, irq_out}, 32'h0, "R7 signal gate closed");
        wr(3'd5, 32'h2);
        rd_check(3'd5, 32'h2, "R7");
        @(negedge clk);
        check({31'b0, irq_out}, 32'h1, "R7 both gates open");
        wr(3'd3, 32'h2);
        @(negedge clk);
        check({31'b0, irq_out}, 32'h0, "R7 after clear");

        // R8/R9: card detect
        @(negedge clk); cd1_n = 1'b0;
        cycles(20);
        rd_check(3'd1, 32'h0, "R8 one pin low");
        rd_check(3'd0, 32'h0000_0008, "R10 pins");
        cd2_n = 1'b0;
        cycles(3);
        rd_check(3'd1, 32'h0, "R9 before window");
        cycles(15);
        rd_check(3'd1, 32'h1, "R8 insertion");
        wr(3'd1, 32'h1);
        rd_check(3'd1, 32'h0, "R2");
        @(negedge clk); cd1_n = 1'b1;
        cycles(3); cd1_n = 1'b0;
        cycles(20);
        rd_check(3'd1, 32'h0, "R9 glitch");
        cd1_n = 1'b1;
        cycles(20);
        rd_check(3'd1, 32'h1, "R8 removal");

        // R10: ready levels
        card_rdy = 1'b1; io_rdy = 1'b1;
        cycles(1);
        rd_check(3'd0, 32'h0000_0064, "R10 ready bits");

        finish_run();
    end
endmodule